// File: doc/BRIEF.md
# CAN Error and Overload Signalling Sequencer

This block decides, bit by bit, what a CAN node puts on the bus while it signals an error or an overload condition. It steps once for every sampled bit, on a one-cycle sample strobe. Its inputs are the sampled bus level, a one-bit-time pulse from the frame logic when an error is found, a pulse when a frame's end-of-frame field is complete, and the node's error-passive status. It returns the transmit level and a 3-bit phase code, and it flags the detection of a start of frame or an overload condition with one-cycle pulses.

After its own six-bit flag, the node does not count a fixed delimiter. It keeps sending recessive bits until the bus goes recessive. This absorbs flags from other nodes that started up to one flag later, so the dominant field can stretch from 6 to 12 bits. A three-bit intermission follows the delimiter. A dominant bit in that intermission is read by its position: on the first or second bit it is an overload condition, and on the third bit it is a new start of frame.

Top module: `can_sig_seq`

## Requirements
- R1: A synchronous reset puts the block in bus idle. In bus idle, phase is 0 (phase codes: 0 idle, 1 frame, 2 error flag, 3 overload flag, 4 wait for recessive, 5 delimiter, 6 intermission), tx_bit is 1 (recessive; 0 is dominant), and both pulses are low.
- R2: State changes only on a cycle where bit_tick is high. With bit_tick low, bus_rx, err_det and frame_end have no effect on phase, tx_bit or the pulses.
- R3: In idle, a dominant sample raises sof_pulse and moves to phase 1. In idle or in frame, err_det starts an error flag (phase 2) from the next bit. When both occur in idle, err_det wins and there is no sof_pulse.
- R4: An error-active node (err_passive=0 when the flag starts) sends an error flag of exactly 6 dominant bits in phase 2.
- R5: An error-passive node sends 6 recessive bits in phase 2, even when the bus is dominant.
- R6: After any flag the node sends recessive bits in phase 4 for as many dominant samples as the bus shows. This covers a superposed flag field of up to 12 dominant bits.
- R7: The first recessive sample in phase 4 counts as delimiter bit 1. After 7 more recessive samples in phase 5 the block enters intermission (phase 6). A dominant sample during the delimiter starts an error flag.
- R8: A dominant sample on intermission bit 1 or 2 raises ovl_pulse. An overload flag of 6 dominant bits (phase 3) follows, whatever err_passive is, and then the same wait and delimiter steps.
- R9: A dominant sample on intermission bit 3 raises sof_pulse and moves to phase 1. It does not start an overload flag.
- R10: err_det is ignored during intermission. Three recessive intermission bits lead to idle.
- R11: frame_end during phase 1 moves the block to intermission, starting at intermission bit 1.
- R12: sof_pulse and ovl_pulse are never high together, and each is high only on a bit_tick cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | Sample strobe, one cycle per bit |
| bus_rx | input | 1 | Sampled bus level (0 dominant) |
| err_det | input | 1 | Error detected in the current bit |
| err_passive | input | 1 | Node is error passive |
| frame_end | input | 1 | Frame completed its end-of-frame field |
| tx_bit | output | 1 | Transmit level (0 dominant) |
| phase | output | 3 | Current phase code |
| sof_pulse | output | 1 | Start of frame accepted |
| ovl_pulse | output | 1 | Overload condition detected |

## Verification
The hardest cases to reach are the late offset flag and the split intermission decision. The first is a wait phase that stays up for six extra dominant bits after the node's own flag. The second is a dominant bit that lands exactly on intermission bit 2 or bit 3. The stimulus table scripts whole bus histories: an error flag followed by another node's flag field, a delimiter into intermission, and then a dominant bit placed on a chosen intermission slot. Each bit uses one strobe followed by a gap cycle. The gap cycle drives conflicting inputs to show that they have no effect.

// File: rtl/can_sig_pkg.sv
package can_sig_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_FRAME  = 3'd1,
    PH_EFLAG  = 3'd2,
    PH_OFLAG  = 3'd3,
    PH_WAIT   = 3'd4,
    PH_DELIM  = 3'd5,
    PH_INTERM = 3'd6
  } can_phase_e;

  // True when a zero-based bit position is the final one of a field of len bits.
  function automatic logic slot_is_last(input int unsigned pos, input int unsigned len);
    return pos == len - 1;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Level driven on the bus for a phase: only flags may be dominant (0).
  function automatic logic drive_level(input can_phase_e ph, input logic passive_flag);
    case (ph)
      PH_EFLAG: return passive_flag;
      PH_OFLAG: return 1'b0;
      default:  return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/can_sig_bitcnt.sv
module can_sig_bitcnt #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (ld)  cnt <= ld_val;
    else if (inc) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/can_sig_txdrv.sv
module can_sig_txdrv
  import can_sig_pkg::*;
(
  input  can_phase_e ph,
  input  logic       passive_flag,
  output logic       tx_bit
);
  always_comb tx_bit = drive_level(ph, passive_flag);
endmodule

// File: rtl/can_sig_seq.sv
module can_sig_seq
  import can_sig_pkg::*;
#(
  parameter int unsigned FLAG_BITS   = 6,
  parameter int unsigned DELIM_BITS  = 8,
  parameter int unsigned INTERM_BITS = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_tick,
  input  logic       bus_rx,
  input  logic       err_det,
  input  logic       err_passive,
  input  logic       frame_end,
  output logic       tx_bit,
  output logic [2:0] phase,
  output logic       sof_pulse,
  output logic       ovl_pulse
);
  localparam int unsigned LONGEST = max3(FLAG_BITS, DELIM_BITS, INTERM_BITS);
  localparam int unsigned CW      = $clog2(LONGEST + 1);

  can_phase_e    st_q, st_d;
  logic          pas_q, pas_d;
  logic [CW-1:0] cnt;
  logic          cnt_ld, cnt_inc;
  logic [CW-1:0] cnt_ldv;

  // Named internal events, used by the checker.
  logic bus_dom_w, flag_last_w, delim_last_w, interm_last_w;
  assign bus_dom_w     = ~bus_rx;
  assign flag_last_w   = slot_is_last(32'(cnt), FLAG_BITS);
  assign delim_last_w  = slot_is_last(32'(cnt), DELIM_BITS);
  assign interm_last_w = slot_is_last(32'(cnt), INTERM_BITS);

  always_comb begin
    st_d      = st_q;
    pas_d     = pas_q;
    cnt_ld    = 1'b0;
    cnt_ldv   = '0;
    cnt_inc   = 1'b0;
    sof_pulse = 1'b0;
    ovl_pulse = 1'b0;
    if (bit_tick) begin
      case (st_q)
        PH_IDLE, PH_FRAME: begin
          if (err_det) begin
            st_d   = PH_EFLAG;
            pas_d  = err_passive;
            cnt_ld = 1'b1;
          end else if (st_q == PH_IDLE && bus_dom_w) begin
            st_d      = PH_FRAME;
            sof_pulse = 1'b1;
          end else if (st_q == PH_FRAME && frame_end) begin
            st_d   = PH_INTERM;
            cnt_ld = 1'b1;
          end
        end
        PH_EFLAG, PH_OFLAG: begin
          if (flag_last_w) st_d = PH_WAIT;
          else             cnt_inc = 1'b1;
        end
        PH_WAIT: begin
          if (!bus_dom_w) begin
            st_d    = PH_DELIM;
            cnt_ld  = 1'b1;
            cnt_ldv = CW'(1);
          end
        end
        PH_DELIM: begin
          if (bus_dom_w) begin
            st_d   = PH_EFLAG;
            pas_d  = err_passive;
            cnt_ld = 1'b1;
          end else if (delim_last_w) begin
            st_d   = PH_INTERM;
            cnt_ld = 1'b1;
          end else begin
            cnt_inc = 1'b1;
          end
        end
        PH_INTERM: begin
          if (bus_dom_w) begin
            if (interm_last_w) begin
              st_d      = PH_FRAME;
              sof_pulse = 1'b1;
            end else begin
              st_d      = PH_OFLAG;
              ovl_pulse = 1'b1;
              cnt_ld    = 1'b1;
            end
          end else if (interm_last_w) begin
            st_d = PH_IDLE;
          end else begin
            cnt_inc = 1'b1;
          end
        end
        default: st_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= PH_IDLE;
      pas_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      pas_q <= pas_d;
    end
  end

  can_sig_bitcnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .ld(cnt_ld), .ld_val(cnt_ldv), .inc(cnt_inc), .cnt(cnt)
  );

  can_sig_txdrv u_tx (.ph(st_q), .passive_flag(pas_q), .tx_bit(tx_bit));

  assign phase = st_q;
endmodule

// File: rtl/can_sig_seq_chk.sv
module can_sig_seq_chk
  import can_sig_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       bit_tick,
  input logic       err_det,
  input logic       tx_bit,
  input logic [2:0] phase,
  input logic       sof_pulse,
  input logic       ovl_pulse,
  input logic       flag_last_w
);
  a_r12_pulse_excl: assert property (@(posedge clk) disable iff (rst)
    !(sof_pulse && ovl_pulse));

  a_r12_pulse_on_tick: assert property (@(posedge clk) disable iff (rst)
    (sof_pulse || ovl_pulse) |-> bit_tick);

  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    !bit_tick |=> $stable(phase));

  a_r8_ovl_flag_dominant: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_OFLAG) |-> !tx_bit);

  a_r6_recessive_outside_flag: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_OFLAG && phase != PH_EFLAG) |-> tx_bit);

  a_r8_ovl_enters_flag: assert property (@(posedge clk) disable iff (rst)
    ovl_pulse |=> (phase == PH_OFLAG));

  a_r9_sof_enters_frame: assert property (@(posedge clk) disable iff (rst)
    sof_pulse |=> (phase == PH_FRAME));

  a_r10_no_error_in_interm: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && err_det && phase == PH_INTERM) |=> (phase != PH_EFLAG));

  a_r4_flag_length_end: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && flag_last_w && (phase == PH_EFLAG || phase == PH_OFLAG))
      |=> (phase == PH_WAIT));
endmodule

bind can_sig_seq can_sig_seq_chk u_chk (
  .clk(clk), .rst(rst), .bit_tick(bit_tick), .err_det(err_det), .tx_bit(tx_bit),
  .phase(phase), .sof_pulse(sof_pulse), .ovl_pulse(ovl_pulse), .flag_last_w(flag_last_w)
);

// File: tb/can_sig_seq_bench.sv
module can_sig_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSEG = 37;

  logic clk = 1'b0, rst = 1'b1, bit_tick = 1'b0, bus_rx = 1'b1;
  logic err_det = 1'b0, err_passive = 1'b0, frame_end = 1'b0;
  logic tx_bit, sof_pulse, ovl_pulse;
  logic [2:0] phase;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_sig_seq u_can_sig_seq (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .bus_rx(bus_rx), .err_det(err_det),
    .err_passive(err_passive), .frame_end(frame_end), .tx_bit(tx_bit), .phase(phase),
    .sof_pulse(sof_pulse), .ovl_pulse(ovl_pulse)
  );

  // {repeat count, {rx,err,pas,fend}, phase after, {tx after, sof, ovl}}
  localparam logic [13:0] SEGS [0:NSEG-1] = '{
    {4'd1,4'b1000,3'd0,3'b100},  // R1 idle stays idle
    {4'd1,4'b0000,3'd1,3'b110},  // R3 start of frame
    {4'd1,4'b1100,3'd2,3'b000},  // R3 error -> active flag
    {4'd5,4'b0000,3'd2,3'b000},  // R4 flag bits
    {4'd1,4'b0000,3'd4,3'b100},  // R4 flag ends after 6
    {4'd6,4'b0000,3'd4,3'b100},  // R6 offset flag from another node
    {4'd1,4'b1000,3'd5,3'b100},  // R7 delimiter bit 1
    {4'd6,4'b1000,3'd5,3'b100},  // R7
    {4'd1,4'b1000,3'd6,3'b100},  // R7 into intermission
    {4'd1,4'b1000,3'd6,3'b100},  // intermission bit 1 recessive
    {4'd1,4'b0000,3'd3,3'b001},  // R8 dominant on bit 2
    {4'd5,4'b0000,3'd3,3'b000},  // R8
    {4'd1,4'b0000,3'd4,3'b100},  // R8 overload flag ends
    {4'd1,4'b1000,3'd5,3'b100},
    {4'd6,4'b1000,3'd5,3'b100},
    {4'd1,4'b1000,3'd6,3'b100},
    {4'd2,4'b1000,3'd6,3'b100},
    {4'd1,4'b0000,3'd1,3'b110},  // R9 dominant on bit 3 = SOF
    {4'd1,4'b1110,3'd2,3'b100},  // R5 passive flag
    {4'd5,4'b0010,3'd2,3'b100},  // R5 recessive despite dominant bus
    {4'd1,4'b0010,3'd4,3'b100},
    {4'd1,4'b1000,3'd5,3'b100},
    {4'd6,4'b1000,3'd5,3'b100},
    {4'd1,4'b1000,3'd6,3'b100},
    {4'd1,4'b1100,3'd6,3'b100},  // R10 error ignored
    {4'd1,4'b1000,3'd6,3'b100},
    {4'd1,4'b1000,3'd0,3'b100},  // R10 back to idle
    {4'd1,4'b0000,3'd1,3'b110},
    {4'd1,4'b1001,3'd6,3'b100},  // R11 frame end
    {4'd1,4'b0000,3'd3,3'b001},  // R8 dominant on bit 1
    {4'd5,4'b0000,3'd3,3'b000},
    {4'd1,4'b0000,3'd4,3'b100},
    {4'd1,4'b1000,3'd5,3'b100},
    {4'd1,4'b0000,3'd2,3'b000},  // R7 dominant in delimiter
    {4'd5,4'b0000,3'd2,3'b000},
    {4'd1,4'b1000,3'd4,3'b100},
    {4'd1,4'b1000,3'd5,3'b100}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One bit: strobe cycle then a gap cycle with conflicting inputs (R2).
  task automatic do_bit(input logic [3:0] ins, input logic [2:0] eph,
                        input logic [2:0] outs, input string req);
    logic [2:0] ph_before;
    @(negedge clk);
    {bus_rx, err_det, err_passive, frame_end} = ins;
    bit_tick = 1'b1;
    #2;
    check({req, " sof"}, sof_pulse, outs[1]);
    check({req, " ovl (R12)"}, ovl_pulse, outs[0]);
    @(negedge clk);
    bit_tick = 1'b0; bus_rx = 1'b0; err_det = 1'b1; frame_end = 1'b1;
    #2;
    check({req, " phase"}, phase, eph);
    check({req, " tx"}, tx_bit, outs[2]);
    check("R2 gap no sof", sof_pulse, 0);
    check("R2 gap no ovl", ovl_pulse, 0);
    ph_before = phase;
    @(negedge clk);
    check("R2 hold phase", phase, ph_before);
    err_det = 1'b0; frame_end = 1'b0; bus_rx = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bit_tick = 1'b0; err_det = 1'b0; frame_end = 1'b0; bus_rx = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    #2;
    check("R1 reset phase", phase, 0);
    check("R1 reset tx", tx_bit, 1);
    check("R1 reset sof", sof_pulse, 0);
    check("R1 reset ovl", ovl_pulse, 0);

    for (int s = 0; s < NSEG; s++) begin
      for (int r = 0; r < int'(SEGS[s][13:10]); r++) begin
        do_bit(SEGS[s][9:6], SEGS[s][5:3], SEGS[s][2:0], $sformatf("seg%0d", s));
      end
    end

    // R3: error beats start of frame in idle.
    do_reset();
    do_bit(4'b0100, 3'd2, 3'b000, "R3 err over sof");

    // R1: reset in the middle of a flag returns to idle.
    do_bit(4'b0000, 3'd2, 3'b000, "R4 flag bit");
    do_reset();
    #2;
    check("R1 mid-flag reset phase", phase, 0);
    check("R1 mid-flag reset tx", tx_bit, 1);

    // R6: a long dominant field keeps the node waiting.
    do_bit(4'b0000, 3'd1, 3'b110, "R3 sof");
    do_bit(4'b0100, 3'd2, 3'b000, "R4 start");
    for (int i = 0; i < 5; i++) do_bit(4'b0000, 3'd2, 3'b000, "R4 run");
    do_bit(4'b0000, 3'd4, 3'b100, "R6 wait");
    for (int i = 0; i < 6; i++) do_bit(4'b0000, 3'd4, 3'b100, "R6 held");
    do_bit(4'b1000, 3'd5, 3'b100, "R7 first recessive");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule